// File: doc/BRIEF.md
# Register Context Save/Restore Sequencer

This block saves a processor's general register context to memory in a privileged backup operation and loads it back in a restore operation. The context is 21 words: the base pointer and the twenty general registers R0 to R19. The stack pointer, instruction pointer, exception flags and I/O ports are never part of the context. The block has a read port and a write port into the register file and a one-word memory port with a ready handshake. It also holds the stack pointer for the length of an operation and reports every change of it.

A command is sampled with the current stack pointer. A backup works like a series of pushes: the pointer moves up by one, then a word is written there. A restore works like a series of pops: a word is read at the pointer, then the pointer moves down by one. A backup followed by a restore therefore leaves the pointer where it started. Addresses are physical, so there is no translation.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `mem_req`, `rf_we` and `sp_we` are all low.
- R2: Register-file index 0 is the base pointer, and index k+1 is general register Rk. A backup writes indices 0, 1, …, 20 in that order to addresses SP+1, SP+2, …, SP+21, where SP is the value of `sp_in` when the command is taken.
- R3: During a backup the pointer is incremented before each write. Each accepted write is followed on the next cycle by an `sp_we` pulse whose `sp_out` equals the written address. The final pointer is SP+21.
- R4: A restore reads addresses SP, SP-1, …, SP-20 and writes those words to register-file indices 20, 19, …, 0 in that order. Each register write carries the word read in the previous cycle.
- R5: During a restore the pointer is decremented after each read. Each accepted read is followed by an `sp_we` pulse whose `sp_out` is the read address minus one. The final pointer is SP-21, so a backup followed by a restore restores the original pointer.
- R6: While `mem_ready` is low, `mem_req`, `mem_addr` and `mem_we` hold steady. Exactly 21 handshakes occur per operation.
- R7: `done` is high for exactly one cycle, in the cycle after the 21st handshake. `busy` is low in that cycle.
- R8: A command that arrives while the block is busy is ignored. This includes the cycle of the final handshake. Such a command never raises `illegal` and does not change the transfer count or the stored data.
- R9: A command with `cmd_priv` low while idle raises `illegal` for one cycle on the next cycle. It produces no memory request, no register write and no pointer change.
- R10: `cmd_load` selects the operation: 0 is backup, 1 is restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_load | input | 1 | 0 = backup, 1 = restore |
| cmd_priv | input | 1 | 1 when the issuing code runs privileged |
| sp_in | input | ADDR_W | Current stack pointer, sampled on command |
| sp_out | output | ADDR_W | Updated stack pointer |
| sp_we | output | 1 | Stack pointer update strobe |
| rf_raddr | output | IDX_W | Register-file read index |
| rf_rdata | input | DATA_W | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | IDX_W | Register-file write index |
| rf_wdata | output | DATA_W | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or completes the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse |

## Verification
Two events can fall in the same clock edge: the completion of the final handshake, which returns the block to idle, and the arrival of a new command. The bench provokes this by holding `cmd_valid` high from the start of a restore until it sees `done`. The command is therefore present at the edge of the last handshake. The bench judges the outcome by three things: exactly 21 handshakes and one `done` pulse, no second operation starting, and register contents that match the memory image. Random `mem_ready` stalls also move the final handshake to a different cycle on each run.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

  typedef enum logic {
    OP_SAVE = 1'b0,
    OP_LOAD = 1'b1
  } seq_op_e;
endpackage

// File: rtl/ctx_slot_map.sv
module ctx_slot_map
  import ctx_seq_pkg::*;
#(
  parameter int NUM_REGS    = 21,
  parameter bit MIRROR_LOAD = 1'b1,
  parameter int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] pos,
  input  seq_op_e          op,
  output logic [IDX_W-1:0] slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  generate
    if (MIRROR_LOAD) begin : g_mirror
      // restore walks the save order backwards
      always_comb slot = (op == OP_LOAD) ? (LAST - pos) : pos;
    end else begin : g_same
      always_comb slot = pos;
    end
  endgenerate
endmodule

// File: rtl/ctx_sp_unit.sv
module ctx_sp_unit
  import ctx_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  seq_op_e           op,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] access_addr,
  output logic              sp_we
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // push writes above the pointer, pop reads at it
  always_comb access_addr = (op == OP_SAVE) ? (sp_q + ONE) : sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      sp_we <= 1'b0;
    end else begin
      sp_we <= step;
      if (load) begin
        sp_q <= load_val;
      end else if (step) begin
        sp_q <= (op == OP_SAVE) ? (sp_q + ONE) : (sp_q - ONE);
      end
    end
  end
endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
  import ctx_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 21,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_load,
  input  logic              cmd_priv,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [ADDR_W-1:0] sp_out,
  output logic              sp_we,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic              illegal
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(NUM_REGS - 1);

  seq_state_e        state;
  seq_op_e           op_q;
  logic [IDX_W-1:0]  pos_q;
  logic [IDX_W-1:0]  slot_cur;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] access_addr;
  logic              start;
  logic              xfer_ok;

  assign start   = (state == ST_IDLE) && cmd_valid && cmd_priv;
  assign xfer_ok = (state == ST_XFER) && mem_ready;
  assign busy    = (state != ST_IDLE);
  assign sp_out  = sp_q;
  assign rf_raddr = slot_cur;

  ctx_slot_map #(.NUM_REGS(NUM_REGS), .MIRROR_LOAD(1'b1), .IDX_W(IDX_W)) u_map (
    .pos  (pos_q),
    .op   (op_q),
    .slot (slot_cur)
  );

  ctx_sp_unit #(.ADDR_W(ADDR_W)) u_sp (
    .clk         (clk),
    .rst         (rst),
    .load        (start),
    .load_val    (sp_in),
    .step        (xfer_ok),
    .op          (op_q),
    .sp_q        (sp_q),
    .access_addr (access_addr),
    .sp_we       (sp_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_SAVE;
      pos_q     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      done      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      rf_we   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (cmd_priv) begin
              op_q  <= cmd_load ? OP_LOAD : OP_SAVE;
              pos_q <= '0;
              state <= ST_PREP;
            end else begin
              illegal <= 1'b1;
            end
          end
        end
        ST_PREP: begin
          mem_req   <= 1'b1;
          mem_we    <= (op_q == OP_SAVE);
          mem_addr  <= access_addr;
          mem_wdata <= rf_rdata;
          state     <= ST_XFER;
        end
        ST_XFER: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (op_q == OP_LOAD) begin
              rf_we    <= 1'b1;
              rf_waddr <= slot_cur;
              rf_wdata <= mem_rdata;
            end
            if (pos_q == LAST_POS) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              pos_q <= pos_q + 1'b1;
              state <= ST_PREP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: request and its address hold through a stall
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3: a push lands the pointer on the address just written
  a_r3_save_sp: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready && mem_we |=> sp_we && (sp_out == $past(mem_addr)));

  // R5: a pop leaves the pointer one below the address read
  a_r5_load_sp: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready && !mem_we |=> sp_we && (sp_out == ADDR_W'($past(mem_addr) - 1'b1)));

  // R4: every register write carries the word of the preceding read
  a_r4_rf_write: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(mem_req && mem_ready && !mem_we) && (rf_wdata == $past(mem_rdata)));

  // R9: unprivileged command while idle traps without traffic
  a_r9_user_trap: assert property (@(posedge clk) disable iff (rst)
    !busy && cmd_valid && !cmd_priv |=> illegal && !mem_req && !busy);

  // R7: completion pulse only when idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !mem_req);

  // R8: commands seen while busy never trap
  a_r8_busy_no_trap: assert property (@(posedge clk) disable iff (rst)
    busy |=> !illegal);
endmodule

// File: tb/ctx_save_seq_test.sv
module ctx_save_seq_test;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int NR = 21;
  localparam int IW = $clog2(NR);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_load = 0, cmd_priv = 0;
  logic [AW-1:0] sp_model = '0;
  logic [AW-1:0] sp_out;
  logic sp_we;
  logic [IW-1:0] rf_raddr, rf_waddr;
  logic [DW-1:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;
  logic rf_we, mem_req, mem_we, busy, done, illegal;
  logic [AW-1:0] mem_addr;
  logic mem_ready = 1'b0;

  logic [DW-1:0] rf [NR];
  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_rf [NR];

  logic          poke_en = 0, poke_mem = 0;
  logic [7:0]    poke_addr = '0;
  logic [DW-1:0] poke_data = '0;

  int xfers, dones, traps, tests, fails;

  ctx_save_seq #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_load(cmd_load), .cmd_priv(cmd_priv),
    .sp_in(sp_model), .sp_out(sp_out), .sp_we(sp_we),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .illegal(illegal)
  );

  assign rf_rdata  = (int'(rf_raddr) < NR) ? rf[rf_raddr] : '0;
  assign mem_rdata = mem[mem_addr[7:0]];

  // models of register file, memory and pointer; plus monitors
  always @(posedge clk) begin
    if (poke_en) begin
      if (poke_mem) mem[poke_addr] <= poke_data;
      else          rf[poke_addr[IW-1:0]] <= poke_data;
    end
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (sp_we) sp_model <= sp_out;
    if (mem_req && mem_ready) xfers <= xfers + 1;
    if (done) dones <= dones + 1;
    if (illegal) traps <= traps + 1;
  end

  // random memory stalls
  initial begin
    void'($urandom(32'd4711));
    forever begin
      @(negedge clk);
      mem_ready = ($urandom_range(0, 3) != 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input bit to_mem, input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    poke_en = 1; poke_mem = to_mem; poke_addr = 8'(addr); poke_data = data;
    @(negedge clk);
    poke_en = 0;
  endtask

  task automatic fill_rf();
    for (int i = 0; i < NR; i++) begin
      logic [DW-1:0] v;
      v = DW'($urandom);
      poke(0, i, v);
      exp_rf[i] = v;
    end
  endtask

  task automatic clear_counts();
    @(negedge clk);
    xfers = 0; dones = 0; traps = 0;
  endtask

  // issue a privileged command; hold keeps cmd_valid high until done is seen
  task automatic run_op(input bit load, input logic [AW-1:0] sp0, input bit hold,
                        input bit poke_mid, output int cycles);
    clear_counts();
    sp_model = sp0;
    cmd_valid = 1; cmd_load = load; cmd_priv = 1;
    @(negedge clk);
    if (!hold) cmd_valid = 0;
    cycles = 0;
    while (!done && cycles < 2000) begin
      if (poke_mid && cycles == 5) begin
        cmd_valid = 1; cmd_load = ~load; cmd_priv = 0;
      end else if (poke_mid && cycles == 7) begin
        cmd_valid = 0; cmd_priv = 1;
      end
      @(negedge clk);
      cycles++;
    end
    cmd_valid = 0;
    check(done, "R7 done seen", int'(done), 1);
    check(!busy, "R7 idle with done", int'(busy), 0);
    check(xfers == NR, "R6 transfer count", xfers, NR);
    @(negedge clk);
    check(!done && dones == 1, "R7 single done pulse", dones, 1);
    @(negedge clk);
    check(!busy && !mem_req, "R8 no restart", int'(busy), 0);
    check(traps == 0, "R8 no trap while busy", traps, 0);
  endtask

  task automatic do_save(input logic [AW-1:0] sp0, input bit poke_mid);
    int cyc;
    run_op(0, sp0, 0, poke_mid, cyc);
    for (int k = 0; k < NR; k++) begin
      logic [DW-1:0] got;
      got = mem[8'(sp0 + AW'(k + 1))];
      check(got == exp_rf[k], "R2 R10 save word order", int'(got), int'(exp_rf[k]));
    end
    check(sp_model == AW'(sp0 + AW'(NR)), "R3 final pointer after save", int'(sp_model), int'(sp0 + AW'(NR)));
  endtask

  task automatic do_restore(input logic [AW-1:0] sp0, input bit hold);
    int cyc;
    run_op(1, sp0, hold, 0, cyc);
    for (int k = 0; k < NR; k++) begin
      check(rf[k] == exp_rf[k], "R4 R10 restored register", int'(rf[k]), int'(exp_rf[k]));
    end
    check(sp_model == AW'(sp0 - AW'(NR)), "R5 final pointer after restore", int'(sp_model), int'(sp0 - AW'(NR)));
  endtask

  initial begin
    tests = 0; fails = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !done && !illegal && !mem_req && !rf_we && !sp_we, "R1 reset outputs",
          int'({busy, done, illegal, mem_req, rf_we, sp_we}), 0);

    // random round trips: save, scramble, restore
    for (int r = 0; r < 6; r++) begin
      logic [AW-1:0] base;
      base = AW'($urandom_range(0, 200)) + AW'(r * 16'h1000);
      fill_rf();
      do_save(base, r == 2);
      for (int i = 0; i < NR; i++) poke(0, i, DW'($urandom));
      do_restore(AW'(base + AW'(NR)), r == 3);
      check(sp_model == base, "R5 round trip pointer", int'(sp_model), int'(base));
    end

    // directed restore from a known memory image, distinct per slot
    begin
      logic [AW-1:0] top;
      top = 16'h00C8;
      for (int k = 0; k < NR; k++) begin
        logic [DW-1:0] v;
        v = DW'(16'hA000 + k * 16'h0111);
        poke(1, int'(top) - k, v);
        exp_rf[NR - 1 - k] = v;
      end
      do_restore(top, 1);
    end

    // unprivileged commands, both kinds
    for (int t = 0; t < 2; t++) begin
      logic [AW-1:0] sp_before;
      clear_counts();
      sp_before = sp_model;
      for (int i = 0; i < NR; i++) exp_rf[i] = rf[i];
      cmd_valid = 1; cmd_load = t[0]; cmd_priv = 0;
      @(negedge clk);
      cmd_valid = 0;
      check(illegal, "R9 trap pulse", int'(illegal), 1);
      check(!busy, "R9 stays idle", int'(busy), 0);
      @(negedge clk);
      check(!illegal, "R9 trap lasts one cycle", int'(illegal), 0);
      repeat (4) @(negedge clk);
      check(xfers == 0 && !mem_req, "R9 no memory traffic", xfers, 0);
      check(sp_model == sp_before, "R9 pointer untouched", int'(sp_model), int'(sp_before));
      for (int i = 0; i < NR; i++)
        check(rf[i] == exp_rf[i], "R9 registers untouched", int'(rf[i]), int'(exp_rf[i]));
    end

    // pointer wrap at the top of the address space
    fill_rf();
    do_save(16'hFFF8, 0);
    do_restore(16'h000D, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule